// File: doc/BRIEF.md
# Configurable Vertical Sync Detector

This block sits at the front of a display-timing path that runs on the dot clock. It takes raw horizontal and vertical sync levels from outside the clock domain and passes each through a synchronizer chain. It then turns them into two single-cycle markers. `line_start_o` marks a chosen edge of each horizontal pulse. `frame_start_o` marks the first qualifying horizontal detection point after the chosen vertical edge has been seen. Later stages count pixels and lines from these two markers.

Four configuration bits set the behaviour:

- **Polarity:** whether the sync inputs are active low or active high.
- **Vertical edge:** which edge of the vertical pulse arms detection, the start or the end of the active period.
- **Detection point:** which horizontal edge acts as the detection point.
- **Line reference:** which horizontal edge the line marker follows.

One combination of the three edge bits is a special case. When all three are set, the detection point is a fixed number of dot clocks after the horizontal leading edge, instead of the trailing edge. The configuration is registered inside the block and cleared by reset. It is expected to be held steady while sync is running.

Top module: `vsync_detector`

## Requirements
- R1: While reset is asserted, both `line_start_o` and `frame_start_o` are 0, and the internal configuration register is all zeros.
- R2: With `cfg_pos_pol_i`=0 a sync input is active while low; with `cfg_pos_pol_i`=1 it is active while high. The leading edge is the start of the active period and the trailing edge is its end.
- R3: With `cfg_h_ref_lead_i`=0, `line_start_o` is high for exactly one cycle, SYNC_STAGES+1 clocks after the horizontal trailing edge reaches the input pin. The default latency is 3 clocks.
- R4: With `cfg_h_ref_lead_i`=1, `line_start_o` pulses with the same latency after the horizontal leading edge. It is never high in two consecutive cycles while the configuration is steady.
- R5: `frame_start_o` is one cycle wide. It fires at the first detection point that lies strictly after the cycle in which the selected vertical edge is seen. Firing consumes that arming.
- R6: `cfg_v_trail_i`=0 arms on the vertical leading edge; `cfg_v_trail_i`=1 arms on the vertical trailing edge.
- R7: Unless R8 applies, the detection point is the horizontal leading edge when `cfg_h_qual_trail_i`=0, and the horizontal trailing edge when it is 1. The output latency matches the line marker.
- R8: When `cfg_v_trail_i`, `cfg_h_qual_trail_i` and `cfg_h_ref_lead_i` are all 1, the detection point is DET_DELAY clocks (default 10) after the horizontal leading edge. A new leading edge restarts that delay.
- R9: Neither output pulses during the first cycles after reset release while the synchronizers fill, whatever level the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Raw horizontal sync level |
| vsync_i | input | 1 | Raw vertical sync level |
| cfg_pos_pol_i | input | 1 | 1: sync inputs are active high |
| cfg_v_trail_i | input | 1 | 1: arm on the vertical trailing edge |
| cfg_h_qual_trail_i | input | 1 | 1: detect at the horizontal trailing edge |
| cfg_h_ref_lead_i | input | 1 | 1: line marker follows the horizontal leading edge |
| line_start_o | output | 1 | One-cycle line marker |
| frame_start_o | output | 1 | One-cycle frame marker |

## Verification
The stimulus is a two-frame raster: 64-clock lines, a 20-clock horizontal pulse, and a vertical pulse three lines long. It is repeated for all sixteen settings of the configuration bits. Crossing polarity with the edge choices shows whether inversion is applied before edge detection, and whether the line marker follows the correct horizontal edge.

Each setting is run with two vertical phases. In the first, the vertical edges fall far from any horizontal edge. This separates leading-edge from trailing-edge arming and detection by the line in which the frame marker lands. In the second, the vertical edges fall inside the horizontal pulse, between its leading edge and the delayed point. This separates the delayed detection mode from ordinary trailing-edge detection, and exercises the rule that detection must come strictly after arming.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   // Registered configuration word
   typedef struct packed {
      logic ref_lead;    // line marker on leading edge
      logic qual_trail;  // detection at trailing edge
      logic v_trail;     // arm on vertical trailing edge
      logic pos_pol;     // inputs active high
   } vsd_cfg_t;

   typedef struct packed {
      logic lead;
      logic trail;
   } vsd_edges_t;

   localparam int unsigned VSD_NUM_CH = 2;
   localparam int unsigned VSD_CH_H   = 0;
   localparam int unsigned VSD_CH_V   = 1;

   function automatic logic vsd_late_mode(input vsd_cfg_t c);
      return c.v_trail & c.qual_trail & c.ref_lead;
   endfunction

endpackage

// File: rtl/vsd_sync_chain.sv
module vsd_sync_chain #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("vsd_sync_chain: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("vsd_sync_chain: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/vsd_edge_pick.sv
module vsd_edge_pick
   import vsd_pkg::*;
#(
   parameter int unsigned WARM = 3
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       lvl_i,
   input  logic       pos_pol_i,
   output vsd_edges_t edges_o
);

   localparam int unsigned WARM_W = $clog2(WARM + 1);

   if (WARM < 1) begin : g_bad_warm
      $error("vsd_edge_pick: WARM must be at least 1");
   end

   logic              active;
   logic              active_q;
   logic [WARM_W-1:0] warm_q;
   logic              ready;

   assign active = pos_pol_i ? lvl_i : ~lvl_i;
   assign ready  = (warm_q == WARM_W'(WARM));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         warm_q   <= '0;
      end else begin
         active_q <= active;
         if (!ready) warm_q <= warm_q + 1'b1;
      end
   end

   assign edges_o.lead  = ready &  active & ~active_q;
   assign edges_o.trail = ready & ~active &  active_q;

endmodule

// File: rtl/vsd_late_tap.sv
module vsd_late_tap #(
   parameter int unsigned DELAY = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic hit_o
);

   localparam int unsigned CNT_W = $clog2(DELAY + 1);

   if (DELAY < 1) begin : g_bad_delay
      $error("vsd_late_tap: DELAY must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign hit_o = run_q && (cnt_q == CNT_W'(DELAY));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(1);
         run_q <= 1'b1;
      end else if (hit_o) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/vsd_frame_arm.sv
module vsd_frame_arm
   import vsd_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  vsd_cfg_t   cfg_i,
   input  vsd_edges_t h_edges_i,
   input  vsd_edges_t v_edges_i,
   input  logic       late_hit_i,
   output logic       frame_o
);

   logic v_sel;
   logic det;
   logic armed_q;
   logic frame_q;

   assign v_sel = cfg_i.v_trail ? v_edges_i.trail : v_edges_i.lead;

   always_comb begin
      if (vsd_late_mode(cfg_i))  det = late_hit_i;
      else if (cfg_i.qual_trail) det = h_edges_i.trail;
      else                       det = h_edges_i.lead;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         frame_q <= 1'b0;
      end else begin
         armed_q <= (armed_q & ~det) | v_sel;
         frame_q <= armed_q & det;
      end
   end

   assign frame_o = frame_q;

   // R5
   frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_q |-> $past(armed_q));

   // R5
   disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_q |-> (armed_q == $past(v_sel)));

   // R8
   late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_q && $past(vsd_late_mode(cfg_i))) |-> $past(late_hit_i));

endmodule

// File: rtl/vsync_detector.sv
module vsync_detector
   import vsd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DET_DELAY   = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hsync_i,
   input  logic vsync_i,
   input  logic cfg_pos_pol_i,
   input  logic cfg_v_trail_i,
   input  logic cfg_h_qual_trail_i,
   input  logic cfg_h_ref_lead_i,
   output logic line_start_o,
   output logic frame_start_o
);

   localparam int unsigned WARM_CYC = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vsync_detector: SYNC_STAGES must be at least 2");
   end
   if (DET_DELAY < 1) begin : g_bad_delay
      $error("vsync_detector: DET_DELAY must be at least 1");
   end

   vsd_cfg_t                cfg_q;
   logic [VSD_NUM_CH-1:0]   raw_lvl;
   logic [VSD_NUM_CH-1:0]   syn_lvl;
   vsd_edges_t              ch_edges [VSD_NUM_CH];
   logic                    late_hit;
   logic                    line_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= '{ref_lead:   cfg_h_ref_lead_i,
                    qual_trail: cfg_h_qual_trail_i,
                    v_trail:    cfg_v_trail_i,
                    pos_pol:    cfg_pos_pol_i};
      end
   end

   assign raw_lvl[VSD_CH_H] = hsync_i;
   assign raw_lvl[VSD_CH_V] = vsync_i;

   vsd_sync_chain #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (VSD_NUM_CH)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_lvl),
      .q_o    (syn_lvl)
   );

   for (genvar ch = 0; ch < VSD_NUM_CH; ch++) begin : g_ch
      vsd_edge_pick #(
         .WARM (WARM_CYC)
      ) u_edge (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .lvl_i     (syn_lvl[ch]),
         .pos_pol_i (cfg_q.pos_pol),
         .edges_o   (ch_edges[ch])
      );
   end

   vsd_late_tap #(
      .DELAY (DET_DELAY)
   ) u_late (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (ch_edges[VSD_CH_H].lead),
      .hit_o   (late_hit)
   );

   vsd_frame_arm u_arm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg_q),
      .h_edges_i  (ch_edges[VSD_CH_H]),
      .v_edges_i  (ch_edges[VSD_CH_V]),
      .late_hit_i (late_hit),
      .frame_o    (frame_start_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_q <= 1'b0;
      end else begin
         line_q <= cfg_q.ref_lead ? ch_edges[VSD_CH_H].lead
                                  : ch_edges[VSD_CH_H].trail;
      end
   end

   assign line_start_o = line_q;

   // R4
   line_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_q |=> (!line_q || ($past(cfg_q, 1) != $past(cfg_q, 2))));

endmodule

// File: tb/vsync_detector_bench.sv
module vsync_detector_bench;

   localparam int LAT   = 3;   // SYNC_STAGES + 1
   localparam int DLY   = 10;
   localparam int LINE  = 64;
   localparam int HBEG  = 40;
   localparam int HEND  = 60;
   localparam int FRM   = 8 * LINE;
   localparam int TOTAL = 2 * FRM;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs = 1'b1, vs = 1'b1;
   logic c_pol = 1'b0, c_vt = 1'b0, c_qt = 1'b0, c_rl = 1'b0;
   logic line_o, frame_o;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int q_line[$];
   int q_frame[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vsync_detector u_vsync_detector (
      .clk_i              (clk),
      .rst_ni             (rst_n),
      .hsync_i            (hs),
      .vsync_i            (vs),
      .cfg_pos_pol_i      (c_pol),
      .cfg_v_trail_i      (c_vt),
      .cfg_h_qual_trail_i (c_qt),
      .cfg_h_ref_lead_i   (c_rl),
      .line_start_o       (line_o),
      .frame_start_o      (frame_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   // Monitor side of the scoreboard: called each negedge
   task automatic monitor(input int n, input string lreq, input string freq);
      bit el, ef;
      el = (q_line.size() > 0) && (q_line[0] == n);
      ef = (q_frame.size() > 0) && (q_frame[0] == n);
      if (el || line_o) check(el == line_o, lreq, int'(line_o), int'(el));
      if (ef || frame_o) check(ef == frame_o, freq, int'(frame_o), int'(ef));
      if (el) void'(q_line.pop_front());
      if (ef) void'(q_frame.pop_front());
   endtask

   task automatic run_case(input bit pol, input bit vt, input bit qt, input bit rl, input int voff);
      bit    late, armed, ph, pv, ah, av, hl, ht, vl, vtr, det, vsel;
      int    lead_n;
      string lreq, freq;
      late   = vt & qt & rl;
      lreq   = rl ? "R4" : "R3";
      freq   = late ? "R8" : (qt ? "R7" : "R6");
      q_line.delete();
      q_frame.delete();
      @(negedge clk);
      rst_n = 1'b0;
      c_pol = pol; c_vt = vt; c_qt = qt; c_rl = rl;
      hs = ~pol; vs = ~pol;
      repeat (3) begin
         @(negedge clk);
         check(!line_o && !frame_o, "R1", int'(line_o) + int'(frame_o), 0);
      end
      rst_n = 1'b1;
      armed = 0; ph = 0; pv = 0; lead_n = -1000;
      for (int t = 0; t < TOTAL + 24; t++) begin
         @(negedge clk);
         if (t < 8) check(!line_o && !frame_o, "R9", int'(line_o) + int'(frame_o), 0);
         monitor(cyc, lreq, freq);
         if (t < TOTAL) begin
            ah = ((t % LINE) >= HBEG) && ((t % LINE) < HEND);
            av = ((t % FRM) >= 2 * LINE + voff) && ((t % FRM) < 5 * LINE + voff);
         end else begin
            ah = ph; av = pv;
         end
         hs = pol ? ah : ~ah;   // R2: active level set by polarity
         vs = pol ? av : ~av;
         hl = ah & ~ph; ht = ~ah & ph;
         vl = av & ~pv; vtr = ~av & pv;
         if (hl) lead_n = cyc;
         if (rl ? hl : ht) q_line.push_back(cyc + LAT);
         if (late) det = (cyc == lead_n + DLY);
         else      det = qt ? ht : hl;
         vsel = vt ? vtr : vl;
         if (det && armed) q_frame.push_back(cyc + LAT);
         armed = (armed & ~det) | vsel;
         ph = ah; pv = av;
      end
      check(q_line.size() == 0, lreq, q_line.size(), 0);
      check(q_frame.size() == 0, "R5", q_frame.size(), 0);
   endtask

   initial begin
      for (int k = 0; k < 16; k++) begin
         run_case(k[0], k[1], k[2], k[3], 10);
         run_case(k[0], k[1], k[2], k[3], 45);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule